// File: doc/BRIEF.md
# Static External Memory Bus Controller

This block connects an internal 32-bit request port to an asynchronous static memory bus with a 20-bit address, a 32-bit data path and four chip-select regions. The requester presents an address, a direction, byte enables and write data, and holds the request until the controller answers with a one-clock done pulse. For reads, the sampled data is returned with that pulse. The two address bits above the 20-bit external address choose which of the four active-low chip selects is driven.

Each chip-select region has its own wait setting from 0 to 3. The setting is loaded through a small configuration port and stretches every access to that region. A read holds chip select and output enable low together for 1 + wait clocks. The data is captured on the clock edge that ends the strobe, while the strobe is still low. A write takes 3 + wait clocks. Chip select and data lead the byte strobes by one clock, the strobes are low for 1 + wait clocks, and chip select and data then stay one more clock after the strobes rise. The data path is split into an output value, an output enable and an input value, so the pad ring can build the tristate buffer.

Top module: `extmem_ctrl`

## Requirements
- R1: After reset, all chip selects, the output enable and all byte write strobes are high, the data output enable is low and done is low.
- R2: For request address bits [21:20] = n, only `mem_cs_n` bit n goes low during the access, and `mem_addr` equals request bits [19:0] and stays unchanged while chip select is low.
- R3: A read drives the chosen chip select and `mem_oe_n` low together for exactly 1 + W consecutive clocks, where W is the wait setting of that chip select. Throughout a read, `mem_we_n` stays all high and `mem_dq_oe` stays low.
- R4: `req_rdata` returns the value present on `mem_dq_in` during the last clock of the read strobe, and keeps it until the next read completes.
- R5: A write holds the chosen chip select low for exactly 3 + W clocks. `mem_we_n` bit i (byte lane i, data bits 8i+7..8i) is low exactly when `req_be` bit i is 1. The strobes go low one clock after chip select falls and stay low for 1 + W clocks. When `req_be` is 0, no strobe falls.
- R6: For every clock of a write's chip-select window, `mem_dq_oe` is high and `mem_dq_out` equals the write data. `mem_oe_n` stays high throughout the write.
- R7: `req_done` is high for exactly one clock, the clock after chip select rises. Request inputs that change while an access is in progress have no effect on that access.
- R8: Each chip select has its own 2-bit wait register, reset to 0. Writing it with `cfg_we` affects only the register chosen by `cfg_sel` and applies to accesses that start later.
- R9: `mem_dq_oe` falls together with chip select at the end of a write. At least one clock with `mem_dq_oe` low lies between any write's data and the next read's output enable falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a wait register |
| cfg_sel | input | 2 | Chip select whose wait register is loaded |
| cfg_wait | input | 2 | Wait value 0..3 |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | [21:20] region, [19:0] external address |
| req_be | input | 4 | Byte enables for a write |
| req_wdata | input | 32 | Write data |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Read data |
| mem_addr | output | 20 | External address |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 4 | Active-low per-lane write strobes |
| mem_dq_out | output | 32 | Data driven to the bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 32 | Data received from the bus |

## Verification
The assertions assume that the requester keeps `req_valid` high until done, and drops it in the done clock or starts a new request only after that clock. They also assume that `mem_dq_in` is only meaningful while the read strobe is low. The bench drives all inputs on the falling edge and releases `req_valid` in the same falling-edge slot in which it sees done. Its memory model returns an address-derived word only while `mem_oe_n` is low and zero otherwise. The bench changes the wait registers only between accesses. In one test it deliberately alters the request fields in the middle of an access, to show that the request port ignores them.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_WSET  = 3'd2,
    PH_WSTB  = 3'd3,
    PH_WHOLD = 3'd4
  } phase_t;

  // total chip-select clocks of one access for a given wait setting
  function automatic int unsigned access_clocks(input logic is_wr, input int unsigned wt);
    return is_wr ? (wt + 3) : (wt + 1);
  endfunction

  // clocks during which a strobe is low
  function automatic int unsigned strobe_clocks(input int unsigned wt);
    return wt + 1;
  endfunction

endpackage

// File: rtl/extmem_wait_regs.sv
module extmem_wait_regs #(
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 2,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WAIT_W-1:0] rd_wait
);
  logic [WAIT_W-1:0] wt_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 wt_q[g] <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(g))    wt_q[g] <= cfg_wait;
    end
  end

  assign rd_wait = wt_q[rd_sel];
endmodule

// File: rtl/extmem_decode.sv
module extmem_decode #(
  parameter int ADDR_W = 20,
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic [ADDR_W+SEL_W-1:0] full_addr,
  output logic [SEL_W-1:0]        region,
  output logic [NUM_CS-1:0]       region_hot,
  output logic [ADDR_W-1:0]       local_addr
);
  assign region     = full_addr[ADDR_W +: SEL_W];
  assign local_addr = full_addr[ADDR_W-1:0];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_hot
    assign region_hot[g] = (region == SEL_W'(g));
  end
endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 2,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NUM_CS-1:0] region_hot,
  input  logic [ADDR_W-1:0] local_addr,
  input  logic [WAIT_W-1:0] wait_val,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] cs_n,
  output logic              oe_n,
  output logic [LANES-1:0]  we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ev_start,
  output logic              busy,
  output logic              acc_wr,
  output logic [WAIT_W-1:0] acc_wait
);
  phase_t            ph;
  logic [WAIT_W-1:0] cnt;
  logic [LANES-1:0]  be_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign ev_start = (ph == PH_IDLE) && req_valid;
  assign busy     = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      mem_addr <= '0;
      cs_n     <= '1;
      oe_n     <= 1'b1;
      we_n     <= '1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      cnt      <= '0;
      be_q     <= '0;
      acc_wr   <= 1'b0;
      acc_wait <= '0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (req_valid) begin
            mem_addr <= local_addr;
            cs_n     <= ~region_hot;
            cnt      <= wait_val;
            acc_wait <= wait_val;
            acc_wr   <= req_write;
            if (req_write) begin
              dq_out <= req_wdata;
              dq_oe  <= 1'b1;
              be_q   <= req_be;
              ph     <= PH_WSET;
            end else begin
              oe_n <= 1'b0;
              ph   <= PH_READ;
            end
          end
        end
        PH_READ: begin
          if (cnt_zero) begin
            rdata <= dq_in;
            cs_n  <= '1;
            oe_n  <= 1'b1;
            done  <= 1'b1;
            ph    <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WSET: begin
          we_n <= ~be_q;
          ph   <= PH_WSTB;
        end
        PH_WSTB: begin
          if (cnt_zero) begin
            we_n <= '1;
            ph   <= PH_WHOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WHOLD: begin
          cs_n  <= '1;
          dq_oe <= 1'b0;
          done  <= 1'b1;
          ph    <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 2,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int LANES = DATA_W / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [WAIT_W-1:0]       cfg_wait,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W+SEL_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_be,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_done,
  output logic [DATA_W-1:0]       req_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NUM_CS-1:0]       mem_cs_n,
  output logic                    mem_oe_n,
  output logic [LANES-1:0]        mem_we_n,
  output logic [DATA_W-1:0]       mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [DATA_W-1:0]       mem_dq_in
);
  logic [SEL_W-1:0]  dec_region;
  logic [NUM_CS-1:0] dec_hot;
  logic [ADDR_W-1:0] dec_local;
  logic [WAIT_W-1:0] sel_wait;
  logic              seq_start;
  logic              seq_busy;
  logic              seq_acc_wr;
  logic [WAIT_W-1:0] seq_acc_wait;

  extmem_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_decode (
    .full_addr  (req_addr),
    .region     (dec_region),
    .region_hot (dec_hot),
    .local_addr (dec_local)
  );

  extmem_wait_regs #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_waits (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wait (cfg_wait),
    .rd_sel   (dec_region),
    .rd_wait  (sel_wait)
  );

  extmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .region_hot (dec_hot),
    .local_addr (dec_local),
    .wait_val   (sel_wait),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .dq_in      (mem_dq_in),
    .mem_addr   (mem_addr),
    .cs_n       (mem_cs_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_out     (mem_dq_out),
    .dq_oe      (mem_dq_oe),
    .done       (req_done),
    .rdata      (req_rdata),
    .ev_start   (seq_start),
    .busy       (seq_busy),
    .acc_wr     (seq_acc_wr),
    .acc_wait   (seq_acc_wait)
  );
endmodule

// File: rtl/extmem_ctrl_chk.sv
module extmem_ctrl_chk
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 2,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic              mem_dq_oe,
  input logic              req_done,
  input logic              ev_start,
  input logic              busy,
  input logic              acc_wr,
  input logic [WAIT_W-1:0] acc_wait
);
  localparam int RUN_W = WAIT_W + 3;
  localparam int MAX_W = (1 << WAIT_W) - 1;

  logic cs_any, we_any;
  logic [RUN_W-1:0] cs_run, oe_run;

  assign cs_any = (mem_cs_n != '1);
  assign we_any = (mem_we_n != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_run <= '0;
      oe_run <= '0;
    end else begin
      if (ev_start)    cs_run <= '0;
      else if (cs_any) cs_run <= cs_run + 1'b1;
      if (!mem_oe_n)   oe_run <= oe_run + 1'b1;
      else             oe_run <= '0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (mem_cs_n == '1 && mem_oe_n && mem_we_n == '1 && !mem_dq_oe && !req_done));

  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_any && $past(cs_any)) |-> $stable(mem_addr));

  a_r3_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> cs_any);

  a_r3_oe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (int'(oe_run) <= MAX_W));

  a_r5_we_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_any) |-> $past(cs_any));

  a_r5_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (int'(cs_run) == int'(access_clocks(acc_wr, int'(acc_wait)))));

  a_r6_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r6_data_under_we: assert property (@(posedge clk) disable iff (!rst_n)
    we_any |-> (mem_dq_oe && cs_any));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r7_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (!cs_any && !busy));

  a_r7_start_drives_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> cs_any);

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

bind extmem_ctrl extmem_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .LANES(LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .req_done  (req_done),
  .ev_start  (seq_start),
  .busy      (seq_busy),
  .acc_wr    (seq_acc_wr),
  .acc_wait  (seq_acc_wait)
);

// File: tb/test_extmem_ctrl.sv
`timescale 1ns/1ps
module test_extmem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_done;
  logic [31:0] req_rdata;
  logic [19:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n;
  logic [3:0]  mem_we_n;
  logic [31:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_in;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int waits [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  // memory model: address-derived word only while the read strobe is low
  assign mem_dq_in = !mem_oe_n ? {12'hA5C, mem_addr} : 32'h0;

  extmem_ctrl i_extmem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitors: read-after-write turnaround and done width
  logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n && prev_oe_n)
        check(!prev_dq_oe, "R9 data released before read strobe", prev_dq_oe, 0);
      if (req_done && prev_done)
        check(1'b0, "R7 done longer than one clock", 2, 1);
    end
    prev_oe_n  = mem_oe_n;
    prev_dq_oe = mem_dq_oe;
    prev_done  = req_done;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic set_wait(input logic [1:0] cs, input logic [1:0] w);
    cfg_we = 1'b1; cfg_sel = cs; cfg_wait = w;
    @(negedge clk);
    cfg_we = 1'b0;
    waits[cs] = int'(w);
  endtask

  // called just after a falling edge; returns in the falling-edge slot where done is seen
  task automatic access(input logic wr, input logic [1:0] cs, input logic [19:0] a,
                        input logic [3:0] be, input logic [31:0] d, input bit scramble);
    int w, exp_len, cs_cnt, oe_cnt, we_cnt, first_we, done_idx;
    bit cs_bad, addr_bad, data_bad, oe_in_wr, we_in_rd;
    logic [3:0] we_pat;
    w = waits[cs];
    exp_len = wr ? w + 3 : w + 1;
    cs_cnt = 0; oe_cnt = 0; we_cnt = 0; first_we = -1; done_idx = -1;
    cs_bad = 0; addr_bad = 0; data_bad = 0; oe_in_wr = 0; we_in_rd = 0; we_pat = 4'hF;
    req_valid = 1'b1; req_write = wr; req_addr = {cs, a}; req_be = be; req_wdata = d;
    for (int idx = 0; idx < 40; idx++) begin
      @(negedge clk);
      if (scramble && idx == 0) begin
        req_addr  = {~cs, ~a};
        req_write = ~wr;
        req_wdata = ~d;
        req_be    = ~be;
      end
      if (mem_cs_n == ~(4'b0001 << cs)) begin
        cs_cnt++;
        if (mem_addr != a) addr_bad = 1;
        if (wr && (!mem_dq_oe || mem_dq_out != d)) data_bad = 1;
        if (wr && !mem_oe_n) oe_in_wr = 1;
        if (!wr && (mem_we_n != 4'hF || mem_dq_oe)) we_in_rd = 1;
      end else if (mem_cs_n != 4'hF) cs_bad = 1;
      if (!mem_oe_n) oe_cnt++;
      if (mem_we_n != 4'hF) begin
        we_cnt++;
        if (first_we < 0) first_we = idx;
        we_pat = mem_we_n;
      end
      if (req_done) begin
        done_idx = idx;
        break;
      end
    end
    req_valid = 1'b0;
    check(!cs_bad, "R2 only the addressed chip select", cs_bad, 0);
    check(!addr_bad, "R2 address held while selected", addr_bad, 0);
    check(done_idx == exp_len, "R7 done in clock after chip select", done_idx, exp_len);
    if (wr) begin
      check(cs_cnt == exp_len, "R5 write chip-select length", cs_cnt, exp_len);
      check(we_cnt == ((be == 4'h0) ? 0 : w + 1), "R5 strobe length", we_cnt, (be == 4'h0) ? 0 : w + 1);
      if (be != 4'h0) begin
        check(first_we == 1, "R5 strobe one clock after chip select", first_we, 1);
        check(we_pat == ~be, "R5 per-lane strobes", we_pat, ~be);
      end
      check(!data_bad, "R6 write data driven for whole access", data_bad, 0);
      check(!oe_in_wr, "R6 read strobe idle during write", oe_in_wr, 0);
      check(!mem_dq_oe, "R9 data released with chip select", mem_dq_oe, 0);
    end else begin
      check(cs_cnt == exp_len, "R3 read chip-select length", cs_cnt, exp_len);
      check(oe_cnt == w + 1, "R3 read strobe length", oe_cnt, w + 1);
      check(!we_in_rd, "R3 no write activity in read", we_in_rd, 0);
      check(req_rdata == {12'hA5C, a}, "R4 read data", req_rdata, {12'hA5C, a});
    end
  endtask

  // {write, cs, wait, be, addr, data}
  localparam logic [60:0] VEC [10] = '{
    {1'b1, 2'd0, 2'd0, 4'hF, 20'h00010, 32'h11223344},
    {1'b0, 2'd0, 2'd0, 4'hF, 20'h00010, 32'h0},
    {1'b1, 2'd1, 2'd1, 4'hF, 20'h0ABCD, 32'hCAFEF00D},
    {1'b0, 2'd1, 2'd1, 4'hF, 20'h0ABCD, 32'h0},
    {1'b1, 2'd2, 2'd2, 4'h3, 20'h12345, 32'h01020304},
    {1'b0, 2'd2, 2'd3, 4'hF, 20'hFFFFF, 32'h0},
    {1'b1, 2'd3, 2'd3, 4'hC, 20'h00000, 32'hA5A5A5A5},
    {1'b0, 2'd3, 2'd0, 4'hF, 20'h80000, 32'h0},
    {1'b0, 2'd1, 2'd2, 4'hF, 20'h55555, 32'h0},
    {1'b1, 2'd0, 2'd1, 4'h8, 20'h7FFFF, 32'hDEADBEEF}
  };

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cs_n == 4'hF, "R1 chip selects idle", mem_cs_n, 4'hF);
    check(mem_oe_n && mem_we_n == 4'hF, "R1 strobes idle", {mem_oe_n, mem_we_n}, 5'h1F);
    check(!mem_dq_oe && !req_done, "R1 driver off and no done", {mem_dq_oe, req_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 wait registers reset to zero: one-clock read on region 2
    access(1'b0, 2'd2, 20'h00042, 4'hF, 32'h0, 1'b0);
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic [60:0] v;
      v = VEC[i];
      if (waits[v[59:58]] != int'(v[57:56])) set_wait(v[59:58], v[57:56]);
      access(v[60], v[59:58], v[51:32], v[55:52], v[31:0], 1'b0);
      @(negedge clk);
    end

    // R8 only the selected register changes
    set_wait(2'd0, 2'd1);
    set_wait(2'd1, 2'd3);
    access(1'b0, 2'd0, 20'h00321, 4'hF, 32'h0, 1'b0);
    @(negedge clk);
    access(1'b0, 2'd1, 20'h00322, 4'hF, 32'h0, 1'b0);
    @(negedge clk);

    // R5 zero byte enables: no strobe
    access(1'b1, 2'd2, 20'h00777, 4'h0, 32'h12345678, 1'b0);
    @(negedge clk);

    // R7 request changes mid-access are ignored
    access(1'b0, 2'd3, 20'h0F0F0, 4'hF, 32'h0, 1'b1);
    @(negedge clk);
    access(1'b1, 2'd1, 20'h0BEEF, 4'h5, 32'h87654321, 1'b1);
    @(negedge clk);

    // R9 back-to-back write then read with no gap from the requester
    access(1'b1, 2'd0, 20'h00100, 4'hF, 32'hFFFF0000, 1'b0);
    access(1'b0, 2'd0, 20'h00100, 4'hF, 32'h0, 1'b0);
    access(1'b1, 2'd3, 20'h00200, 4'h6, 32'h00FF00FF, 1'b0);
    access(1'b0, 2'd2, 20'h00200, 4'hF, 32'h0, 1'b0);
    @(negedge clk);
    check(!req_done, "R7 done drops after one clock", req_done, 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule